// File: doc/BRIEF.md
# Shared-Prescaler Input Debouncer

This block cleans up to 32 slow input lines (buttons, switches, contact sensors) before they reach an edge or level interrupt detector. Every line is first brought into the clock domain by a synchronizer. A line can then also pass through a glitch filter. The filter samples the line only on a shared debounce tick, and the line's output follows a new value only once two successive ticks agree on it.

A single programmable divider produces the tick for all lines, so every filtered line uses the same debounce interval. Software sets that interval in a 24-bit divisor register. A second register holds one filter-enable bit per line. The filter is applied only when the line's filter-enable bit is set and the interrupt enable for that line, supplied by the interrupt logic downstream, is also set. All other lines leave the synchronizer without further delay.

Top module: `dbnc_top`

## Requirements
- R1: After a synchronous active-low reset, the filter-enable register (offset 0x40) and the divisor register (offset 0x44) both read zero, and every output line is 0.
- R2: A write to offset 0x40 loads bit i of the write data as the filter enable for line i. The register reads back at the same offset on the next cycle.
- R3: A write to offset 0x44 stores only bits 23:0 of the write data. A read of that offset returns those bits, with bits 31:24 at zero. A read of any other offset returns zero.
- R4: When a line is not filtered, its output equals its input delayed by exactly two clock cycles.
- R5: A line is filtered only when its filter-enable bit and its interrupt enable are both 1. Clearing either bit switches the line back to the two-cycle synchronized path.
- R6: A filtered output changes only on a tick, and only when the synchronized input had the same value at that tick and at the tick before. A pulse that is seen at only one tick never reaches the output.
- R7: With a divisor value D of 2 or more, a tick occurs every D clock cycles. A divisor of 0 or 1 gives a tick on every cycle.
- R8: A cycle that writes offset 0x44 produces no tick and restarts the divider. The first tick after the write comes D cycles later, where D is the new divisor value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the offset on bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the offset on bus_addr |
| line_in | input | 32 | Raw, asynchronous input lines |
| irq_en | input | 32 | Per-line interrupt enable from the downstream detector |
| line_out | output | 32 | Synchronized, optionally debounced lines |

## Verification
Two functions can fall in the same cycle. A divisor write can land on the cycle in which the divider would have ticked, and an input change can reach the filter on a tick cycle. The bench provokes both by rewriting the divisor repeatedly at varying phases while pseudo-random input patterns change at intervals close to the tick period. A cycle-accurate scoreboard model, built from the requirements, judges every output cycle. It treats a write cycle as tick-free and starts the divider count from zero.

// File: rtl/dbnc_pkg.sv
// Shared constants for the debouncer: register offsets and default sizes.
package dbnc_pkg;
    localparam int unsigned BUS_DW       = 32;
    localparam int unsigned BUS_AW       = 8;
    localparam int unsigned DEF_LINES    = 32;
    localparam int unsigned DEF_DIV_W    = 24;
    localparam int unsigned DEF_SYNC     = 2;
    localparam logic [BUS_AW-1:0] OFS_FILT_EN = 8'h40;
    localparam logic [BUS_AW-1:0] OFS_DIVISOR = 8'h44;
endpackage

// File: rtl/dbnc_regs.sv
// Register file for the debouncer: filter-enable mask and tick divisor.
// Assumes single-cycle writes and a combinational read path; offsets
// that are not mapped read zero and ignore writes.
module dbnc_regs #(
    parameter int unsigned LINES  = 32,
    parameter int unsigned DIV_W  = 24,
    parameter int unsigned AW     = 8,
    parameter int unsigned DW     = 32,
    parameter logic [AW-1:0] EN_OFS  = 8'h40,
    parameter logic [AW-1:0] DIV_OFS = 8'h44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [LINES-1:0] en_q,
    output logic [DIV_W-1:0] div_q,
    output logic             div_wr
);
    logic hit_en;
    logic hit_div;

    // Decode the two mapped offsets.
    always_comb begin
        hit_en  = (addr == EN_OFS);
        hit_div = (addr == DIV_OFS);
        div_wr  = wr && hit_div;
    end

    // Hold the filter-enable mask and the truncated divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            div_q <= '0;
        end else begin
            if (wr && hit_en)  en_q  <= wdata[LINES-1:0];
            if (wr && hit_div) div_q <= wdata[DIV_W-1:0];
        end
    end

    // Drive read data, zero-extending narrower registers.
    always_comb begin
        rdata = '0;
        if (hit_en)       rdata[LINES-1:0] = en_q;
        else if (hit_div) rdata[DIV_W-1:0] = div_q;
    end

    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == EN_OFS) |=> en_q == $past(wdata[LINES-1:0]));
    p_div_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == DIV_OFS) |=> div_q == $past(wdata[DIV_W-1:0]));
endmodule

// File: rtl/dbnc_ticker.sv
// Shared debounce tick divider. It emits one tick every div_q cycles,
// or every cycle when div_q is 0 or 1. A divisor write suppresses the
// tick in that cycle and restarts the count from zero.
module dbnc_ticker #(
    parameter int unsigned DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_q,
    input  logic             div_wr,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // Terminal count; small divisors collapse to a tick every cycle.
    always_comb begin
        lim  = (div_q <= DIV_W'(1)) ? '0 : div_q - DIV_W'(1);
        tick = !div_wr && (cnt_q >= lim);
    end

    // Advance the count, clearing it on a tick or a divisor write.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (div_wr || tick)  cnt_q <= '0;
        else                      cnt_q <= cnt_q + DIV_W'(1);
    end

    p_restart_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (cnt_q == '0));
    p_tick_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/dbnc_lane.sv
// One input line: a synchronizer chain, then a two-tick agreement filter.
// The filter runs at all times. use_filt picks its output or the plain
// synchronized value. Assumes SYNC_STAGES >= 2.
module dbnc_lane #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic tick,
    input  logic use_filt,
    output logic out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   s;
    logic                   last_q;
    logic                   filt_q;

    assign s = sync_q[SYNC_STAGES-1];

    // Shift the raw line through the synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    // On a tick, accept the value only if the previous tick agreed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            filt_q <= 1'b0;
        end else if (tick) begin
            last_q <= s;
            if (s == last_q) filt_q <= s;
        end
    end

    // Select the filtered or synchronized value.
    always_comb out = use_filt ? filt_q : s;

    p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt_q));
    p_disagree_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (s != last_q)) |=> $stable(filt_q));
endmodule

// File: rtl/dbnc_top.sv
// Debouncer top: register file, shared tick divider and one lane per line.
// A line is filtered only when its enable bit and its interrupt enable
// are both set. Assumes LINES <= 32 and DIV_W <= 32.
module dbnc_top
    import dbnc_pkg::*;
#(
    parameter int unsigned LINES       = DEF_LINES,
    parameter int unsigned DIV_W       = DEF_DIV_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [LINES-1:0]  line_in,
    input  logic [LINES-1:0]  irq_en,
    output logic [LINES-1:0]  line_out
);
    logic [LINES-1:0] en_q;
    logic [DIV_W-1:0] div_q;
    logic             div_wr;
    logic             tick;

    dbnc_regs #(
        .LINES(LINES), .DIV_W(DIV_W), .AW(BUS_AW), .DW(BUS_DW),
        .EN_OFS(OFS_FILT_EN), .DIV_OFS(OFS_DIVISOR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .en_q(en_q), .div_q(div_q), .div_wr(div_wr)
    );

    dbnc_ticker #(.DIV_W(DIV_W)) u_ticker (
        .clk(clk), .rst_n(rst_n), .div_q(div_q), .div_wr(div_wr), .tick(tick)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_lane
        dbnc_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk(clk), .rst_n(rst_n), .raw(line_in[i]), .tick(tick),
            .use_filt(en_q[i] & irq_en[i]), .out(line_out[i])
        );
    end
endmodule

// File: tb/dbnc_top_bench.sv
// Scoreboard bench: a reference model pushes the expected line_out every
// cycle, a monitor pops and compares it mid-cycle. Directed register
// checks run alongside.
module dbnc_top_bench;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] line_in = '0;
    logic [31:0] irq_en = '0;
    logic [31:0] line_out;

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R1";
    logic [31:0] lfsr = 32'h1D2C3B4A;
    logic [31:0] exp_q[$];

    // Reference model state.
    logic [31:0] m_s1, m_s2, m_last, m_filt, m_en, m_agree, m_sel;
    logic [23:0] m_div, m_cnt, m_lim;
    logic        m_tk, m_wdiv;

    always #(CLK_P/2) clk = ~clk;

    dbnc_top u_dbnc_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
        .irq_en(irq_en), .line_out(line_out)
    );

    // Model of R1 and R4 to R8, evaluated at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_last = '0; m_filt = '0;
            m_en = '0; m_div = '0; m_cnt = '0;
        end else begin
            m_wdiv = bus_wr && (bus_addr == 8'h44);
            m_lim  = (m_div < 24'd2) ? 24'd0 : m_div - 24'd1;
            m_tk   = !m_wdiv && (m_cnt >= m_lim);
            if (m_tk) begin
                m_agree = ~(m_s2 ^ m_last);
                m_filt  = (m_agree & m_s2) | (~m_agree & m_filt);
                m_last  = m_s2;
            end
            m_s2 = m_s1;
            m_s1 = line_in;
            m_cnt = (m_wdiv || m_tk) ? 24'd0 : m_cnt + 24'd1;
            if (bus_wr && bus_addr == 8'h40) m_en = bus_wdata;
            if (m_wdiv) m_div = bus_wdata[23:0];
        end
        m_sel = m_en & irq_en;
        exp_q.push_back((m_sel & m_filt) | (~m_sel & m_s2));
    end

    // Monitor: compare the output a quarter period after each edge.
    always @(posedge clk) begin
        logic [31:0] e;
        #(CLK_P/4);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if (line_out !== e) begin
                n_fail++;
                $display("FAIL %s line_out actual=%h expected=%h", phase, line_out, e);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic reg_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #(CLK_P/4);
        check(req, bus_rdata, exp);
    endtask

    // Drive pseudo-random input, changing every 'hold' cycles.
    task automatic drive(input int cycles, input int hold);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (c % hold == 0) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                line_in = lfsr;
            end
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL %s watchdog expired actual=running expected=done", phase);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state of both registers and the outputs.
        reg_check("R1", 8'h40, 32'h0);
        reg_check("R1", 8'h44, 32'h0);
        check("R1", line_out, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        // R2 and R3: register access and truncation.
        phase = "R2";
        reg_write(8'h40, 32'h0000_FFFF);
        reg_check("R2", 8'h40, 32'h0000_FFFF);
        phase = "R3";
        reg_write(8'h44, 32'hFFAB_CDEF);
        reg_check("R3", 8'h44, 32'h00AB_CDEF);
        reg_check("R3", 8'h10, 32'h0);
        reg_write(8'h20, 32'hFFFF_FFFF);
        reg_check("R3", 8'h40, 32'h0000_FFFF);

        // R4: no interrupt enable, so every line passes after two cycles.
        phase = "R4";
        irq_en = 32'h0;
        drive(60, 1);

        // R5 and R7: partial overlap of enables, tick every cycle.
        phase = "R5";
        reg_write(8'h44, 32'h0);
        irq_en = 32'h00FF_00FF;
        drive(60, 1);
        reg_write(8'h44, 32'h1);
        phase = "R7";
        drive(60, 2);

        // R6: a one-tick glitch on a filtered line is rejected.
        phase = "R6";
        irq_en = 32'hFFFF_FFFF;
        reg_write(8'h40, 32'hFFFF_FFFF);
        @(negedge clk) line_in = 32'h0;
        reg_write(8'h44, 32'd4);
        repeat (20) @(negedge clk);
        line_in = 32'h1;
        repeat (3) @(negedge clk);
        line_in = 32'h0;
        repeat (20) @(negedge clk);
        #(CLK_P/4);
        check("R6", line_out, 32'h0);
        @(negedge clk) line_in = 32'h1;
        repeat (20) @(negedge clk);
        #(CLK_P/4);
        check("R6", line_out, 32'h1);

        // R7: several divisors with inputs changing near the tick period.
        phase = "R7";
        reg_write(8'h44, 32'd7);
        drive(200, 9);
        drive(200, 15);
        reg_write(8'h40, 32'h5555_AAAA);
        drive(200, 5);

        // R8: divisor rewritten at varying phases, some on tick cycles.
        phase = "R8";
        for (int k = 0; k < 12; k++) begin
            reg_write(8'h44, 32'd3 + 32'(k % 5));
            drive(k + 2, 3);
        end
        drive(100, 4);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule